// File: doc/BRIEF.md
# Column-Associative Data Cache Controller

This block is a direct-mapped data cache that gets close to the miss rate of a two-way set-associative cache. Its hit path stays that of a direct-mapped lookup. Every address has two candidate sets. The primary set is the plain index field of the address. The alternate set is the same field with its top bit inverted. A lookup first tries the primary set and, only when that set is allowed to hold a relocated line, tries the alternate set on the next cycle.

Each set carries a relocation flag (the rehash bit). The flag marks that the line in the set lives at its alternate location. A primary miss on a set whose flag is 1 skips the second probe and refills that set at once. Otherwise the alternate set is probed. A hit there, or a miss on both probes, exchanges the two lines, so the line just used sits at its primary set. The cache is write-through and does not allocate on write misses. Lines are one word wide and the address is a word address.

On the CPU side, a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the CPU must hold its request until it sees ready. The response is a one-cycle strobe with no back-pressure. On the memory side, a request is held, with a stable address, until `mem_req_ready` is seen high. A line fill is a single beat on `mem_fill_valid`, and the controller always takes it.

Top module: `colassoc_cache`

## Requirements
- R1: Out of reset, every set is invalid with its rehash bit 1, `req_ready` is 1, no memory request is raised, no response is given, and all three counters read 0.
- R2: A read that hits in its primary set (index = `addr[IDX_W-1:0]`) gives `resp_valid` one cycle after acceptance, with the line data, `resp_hit`=1 and `resp_second`=0, and causes no memory traffic.
- R3: A second probe of the alternate set (primary index with bit IDX_W-1 inverted) is made only when the primary set misses and its rehash bit is 0. A read hit there responds two cycles after acceptance, with `resp_hit`=1 and `resp_second`=1.
- R4: After a second-probe hit, the two lines are exchanged in one further cycle during which `req_ready` is 0. The next access to the same address hits on the first probe.
- R5: When both probes miss, the line is fetched, written into the alternate set and then exchanged. The fetched address then hits on the first probe, and the displaced line hits on the second probe. After any exchange, the primary set has rehash bit 0 and the alternate set has rehash bit 1.
- R6: A primary miss on a set with rehash bit 1 makes no second probe. The fetched line replaces that set and its rehash bit becomes 0, and the alternate set is left untouched.
- R7: The stored tag is `addr[ADDR_W-1:IDX_W-1]`, which includes the top index bit, so two addresses that differ only in that bit never hit on each other's line.
- R8: A write that hits on either probe updates the cached word and forwards the write (`mem_req_we`=1) to memory. Later reads return the new data without a memory read.
- R9: A write miss is forwarded to memory only. The cache contents stay unchanged, and the response has `resp_hit`=0.
- R10: Each response adds one to exactly one counter: `cnt_hit1` for a first-probe hit, `cnt_hit2` for a second-probe hit, and `cnt_miss` otherwise. With no response, the counters stay constant.
- R11: A memory request keeps `mem_req_valid`, `mem_req_addr`, `mem_req_we` and `mem_req_wdata` stable until `mem_req_ready` is seen high. A read miss returns the data of the single fill beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_rdata | output | DATA_W | Read data (write data echoed for writes) |
| resp_hit | output | 1 | Access hit in the cache |
| resp_second | output | 1 | Hit came from the second probe |
| mem_req_valid | output | 1 | Memory request held until ready |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = forwarded write, 0 = line read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Forwarded write data |
| mem_fill_valid | input | 1 | Single-beat fill data present |
| mem_fill_data | input | DATA_W | Fill data |
| cnt_hit1 | output | CNT_W | First-probe hit count |
| cnt_hit2 | output | CNT_W | Second-probe hit count |
| cnt_miss | output | CNT_W | Miss count |

## Verification
The assertions check on every cycle that a second probe only follows a primary miss on a set whose rehash bit is clear, and that every exchange leaves the rehash bits at 0 (primary) and 1 (alternate). They also check that a written set is valid afterwards, that memory requests hold steady under back-pressure, that the swap cycle stalls the CPU, and that the counters move only with a response. Only the bench's scenarios can show the placement policy itself: which line ends up where after a relocation skip or a double miss, that an alias differing only in the top index bit is refused, and that a write miss leaves the cache untouched. These outcomes are visible only through later accesses and their latency.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE2,
    ST_SWAP,
    ST_MREQ,
    ST_MWAIT,
    ST_WREQ
  } ca_state_e;
endpackage

// File: rtl/ca_index_map.sv
// Primary/alternate set selection and stored tag for one word address.
module ca_index_map #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = ADDR_W - IDX_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx_pri,
  output logic [IDX_W-1:0]  idx_alt,
  output logic [TAG_W-1:0]  tag
);
  localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

  assign idx_pri = addr[IDX_W-1:0];
  assign idx_alt = addr[IDX_W-1:0] ^ FLIP;
  // top index bit kept in the tag so flipped aliases never match
  assign tag     = addr[ADDR_W-1:IDX_W-1];
endmodule

// File: rtl/ca_line_store.sv
// Register-based line arrays: two read ports, one write port, pair exchange.
module ca_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic              ra_rehash,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic              rb_rehash,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_rehash,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx
);
  localparam int SETS = 1 << IDX_W;
  localparam int FLIP = 1 << (IDX_W - 1);

  logic              v_q [SETS];
  logic              r_q [SETS];
  logic [TAG_W-1:0]  t_q [SETS];
  logic [DATA_W-1:0] d_q [SETS];
  logic [SETS-1:0]   v_vec, r_vec;

  for (genvar i = 0; i < SETS; i++) begin : g_set
    localparam int J = i ^ FLIP;
    logic              v, r;
    logic [TAG_W-1:0]  t;
    logic [DATA_W-1:0] d;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v <= 1'b0;
        r <= 1'b1;
        t <= '0;
        d <= '0;
      end else if (sw_en && (sw_idx == IDX_W'(i) || sw_idx == IDX_W'(J))) begin
        // both sets of the pair take the partner's line
        v <= v_q[J];
        t <= t_q[J];
        d <= d_q[J];
        r <= (sw_idx == IDX_W'(J));
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        v <= 1'b1;
        t <= wr_tag;
        d <= wr_data;
        r <= wr_rehash;
      end
    end
    assign v_q[i]   = v;
    assign r_q[i]   = r;
    assign t_q[i]   = t;
    assign d_q[i]   = d;
    assign v_vec[i] = v;
    assign r_vec[i] = r;
  end

  assign ra_valid  = v_q[ra_idx];
  assign ra_rehash = r_q[ra_idx];
  assign ra_tag    = t_q[ra_idx];
  assign ra_data   = d_q[ra_idx];
  assign rb_valid  = v_q[rb_idx];
  assign rb_rehash = r_q[rb_idx];
  assign rb_tag    = t_q[rb_idx];
  assign rb_data   = d_q[rb_idx];

  // R5
  swap_rehash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |=> !r_vec[$past(sw_idx)] && r_vec[$past(sw_idx) ^ IDX_W'(FLIP)]);

  // R6
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !sw_en |=> v_vec[$past(wr_idx)]);
endmodule

// File: rtl/colassoc_cache.sv
module colassoc_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              resp_hit,
  output logic              resp_second,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_fill_valid,
  input  logic [DATA_W-1:0] mem_fill_data,
  output logic [CNT_W-1:0]  cnt_hit1,
  output logic [CNT_W-1:0]  cnt_hit2,
  output logic [CNT_W-1:0]  cnt_miss
);
  import ca_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W + 1;

  ca_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q, swap_q, wrp_q, fillp_q, hit_q, sec_q;
  logic              swap_d, wrp_d, fillp_d, hit_d, sec_d;

  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  idx_p, idx_s;
  logic [TAG_W-1:0]  tag_l;
  logic              pa_valid, pa_rehash, pb_valid, pb_rehash;
  logic [TAG_W-1:0]  pa_tag, pb_tag;
  logic [DATA_W-1:0] pa_data, pb_data;
  logic              hit_p, hit_s, accept;

  logic              wr_en, wr_rehash, sw_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data, rsp_data;
  logic              rsp_fire, rsp_hit, rsp_second;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign look_addr = (state_q == ST_IDLE) ? req_addr : addr_q;

  ca_index_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_map (
    .addr(look_addr), .idx_pri(idx_p), .idx_alt(idx_s), .tag(tag_l)
  );

  ca_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(idx_p), .ra_valid(pa_valid), .ra_rehash(pa_rehash),
    .ra_tag(pa_tag), .ra_data(pa_data),
    .rb_idx(idx_s), .rb_valid(pb_valid), .rb_rehash(pb_rehash),
    .rb_tag(pb_tag), .rb_data(pb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .wr_rehash(wr_rehash), .sw_en(sw_en), .sw_idx(idx_p)
  );

  assign hit_p = pa_valid && (pa_tag == tag_l);
  assign hit_s = pb_valid && (pb_tag == tag_l);

  always_comb begin
    state_d    = state_q;
    swap_d     = swap_q;
    wrp_d      = wrp_q;
    fillp_d    = fillp_q;
    hit_d      = hit_q;
    sec_d      = sec_q;
    wr_en      = 1'b0;
    wr_idx     = idx_p;
    wr_tag     = tag_l;
    wr_data    = pa_data;
    wr_rehash  = 1'b0;
    sw_en      = 1'b0;
    rsp_fire   = 1'b0;
    rsp_data   = pa_data;
    rsp_hit    = 1'b0;
    rsp_second = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        swap_d = 1'b0;
        wrp_d  = 1'b0;
        sec_d  = 1'b0;
        hit_d  = hit_p;
        if (hit_p) begin
          if (req_we) begin
            wr_en     = 1'b1;
            wr_data   = req_wdata;
            wr_rehash = pa_rehash;
            state_d   = ST_WREQ;
          end else begin
            rsp_fire = 1'b1;
            rsp_hit  = 1'b1;
          end
        end else if (pa_rehash) begin
          // relocated line in primary set: replace it, no second probe
          fillp_d = 1'b1;
          state_d = req_we ? ST_WREQ : ST_MREQ;
        end else begin
          state_d = ST_PROBE2;
        end
      end
      ST_PROBE2: begin
        hit_d = hit_s;
        sec_d = hit_s;
        if (hit_s) begin
          state_d = ST_SWAP;
          if (we_q) begin
            wr_en     = 1'b1;
            wr_idx    = idx_s;
            wr_data   = wdata_q;
            wr_rehash = pb_rehash;
            wrp_d     = 1'b1;
          end else begin
            rsp_fire   = 1'b1;
            rsp_data   = pb_data;
            rsp_hit    = 1'b1;
            rsp_second = 1'b1;
          end
        end else if (we_q) begin
          state_d = ST_WREQ;
        end else begin
          fillp_d = 1'b0;
          swap_d  = 1'b1;
          state_d = ST_MREQ;
        end
      end
      ST_SWAP: begin
        sw_en   = 1'b1;
        swap_d  = 1'b0;
        state_d = wrp_q ? ST_WREQ : ST_IDLE;
      end
      ST_MREQ: if (mem_req_ready) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_fill_valid) begin
        wr_en    = 1'b1;
        wr_idx   = fillp_q ? idx_p : idx_s;
        wr_data  = mem_fill_data;
        rsp_fire = 1'b1;
        rsp_data = mem_fill_data;
        state_d  = swap_q ? ST_SWAP : ST_IDLE;
      end
      ST_WREQ: if (mem_req_ready) begin
        rsp_fire   = 1'b1;
        rsp_data   = wdata_q;
        rsp_hit    = hit_q;
        rsp_second = sec_q;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      we_q        <= 1'b0;
      swap_q      <= 1'b0;
      wrp_q       <= 1'b0;
      fillp_q     <= 1'b0;
      hit_q       <= 1'b0;
      sec_q       <= 1'b0;
      resp_valid  <= 1'b0;
      resp_rdata  <= '0;
      resp_hit    <= 1'b0;
      resp_second <= 1'b0;
      cnt_hit1    <= '0;
      cnt_hit2    <= '0;
      cnt_miss    <= '0;
    end else begin
      state_q <= state_d;
      swap_q  <= swap_d;
      wrp_q   <= wrp_d;
      fillp_q <= fillp_d;
      hit_q   <= hit_d;
      sec_q   <= sec_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        we_q    <= req_we;
      end
      resp_valid <= rsp_fire;
      if (rsp_fire) begin
        resp_rdata  <= rsp_data;
        resp_hit    <= rsp_hit;
        resp_second <= rsp_second;
        if (!rsp_hit)       cnt_miss <= cnt_miss + 1'b1;
        else if (rsp_second) cnt_hit2 <= cnt_hit2 + 1'b1;
        else                cnt_hit1 <= cnt_hit1 + 1'b1;
      end
    end
  end

  assign mem_req_valid = (state_q == ST_MREQ) || (state_q == ST_WREQ);
  assign mem_req_we    = (state_q == ST_WREQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  // R3
  probe2_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PROBE2 |-> !$past(pa_rehash) && $past(state_q) == ST_IDLE);

  // R4
  swap_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_second && !we_q |-> !req_ready);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R10
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> $stable(cnt_hit1) && $stable(cnt_hit2) && $stable(cnt_miss));
endmodule

// File: tb/test_colassoc_cache.sv
`timescale 1ns/1ps
module test_colassoc_cache;
  localparam int AW = 16, DW = 32, CW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, resp_valid, resp_hit, resp_second;
  logic [DW-1:0] resp_rdata;
  logic          mem_req_valid, mem_req_we;
  logic          mem_req_ready = 1'b0, mem_fill_valid = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata, mem_fill_data = '0;
  logic [CW-1:0] cnt_hit1, cnt_hit2, cnt_miss;

  colassoc_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(3), .CNT_W(CW)) i_colassoc_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_hit(resp_hit), .resp_second(resp_second),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
    .cnt_hit1(cnt_hit1), .cnt_hit2(cnt_hit2), .cnt_miss(cnt_miss)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int n_rd = 0, n_wr = 0, mem_wait = 0;
  int e_h1 = 0, e_h2 = 0, e_ms = 0;
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;
  logic [DW-1:0] mem_m [logic [AW-1:0]];
  bit done = 0;

  function automatic logic [DW-1:0] mval(logic [AW-1:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // memory responder; also checks request stability while stalled (R11)
  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_fill_valid = 1'b0;
      if (mem_req_valid) begin
        logic [AW-1:0] a0;
        logic          w0;
        logic [DW-1:0] d0;
        a0 = mem_req_addr; w0 = mem_req_we; d0 = mem_req_wdata;
        for (int k = 0; k < mem_wait; k++) begin
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr == a0 && mem_req_we == w0 && mem_req_wdata == d0,
              "R11 request held", DW'(mem_req_addr), DW'(a0));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (w0) begin
          n_wr++; last_wa = a0; last_wd = d0; mem_m[a0] = d0;
        end else begin
          n_rd++;
          mem_fill_valid = 1'b1;
          mem_fill_data  = mval(a0);
          @(negedge clk);
          mem_fill_valid = 1'b0;
        end
      end
    end
  end

  // issue one access; returns response cycles after acceptance
  task automatic issue(bit we, logic [AW-1:0] a, logic [DW-1:0] d, output int cyc,
                       output logic [DW-1:0] rd, output bit h, output bit s, output bit rdy);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!resp_valid) begin @(negedge clk); cyc++; end
    rd = resp_rdata; h = resp_hit; s = resp_second; rdy = req_ready;
  endtask

  // kind: 0 miss, 1 first-probe hit, 2 second-probe hit
  task automatic rd_access(logic [AW-1:0] a, logic [DW-1:0] exp, int kind, string req);
    int cyc, r0;
    logic [DW-1:0] rd;
    bit h, s, rdy;
    r0 = n_rd;
    issue(1'b0, a, '0, cyc, rd, h, s, rdy);
    chk(rd == exp, {req, " read data"}, rd, exp);
    chk(h == (kind != 0) && s == (kind == 2), {req, " hit/second flags"},
        DW'({h, s}), DW'({kind != 0, kind == 2}));
    if (kind == 0) begin
      e_ms++;
      chk(n_rd == r0 + 1, {req, " one line read"}, DW'(n_rd - r0), 1);
    end else begin
      chk(n_rd == r0, {req, " no memory read"}, DW'(n_rd - r0), 0);
      chk(cyc == kind, {req, " latency"}, DW'(cyc), DW'(kind));
    end
    if (kind == 1) e_h1++;
    if (kind == 2) begin
      e_h2++;
      chk(!rdy, "R4 stall in swap cycle", DW'(rdy), 0);
    end
  endtask

  task automatic wr_access(logic [AW-1:0] a, logic [DW-1:0] d, int kind, string req);
    int cyc, w0, r0;
    logic [DW-1:0] rd;
    bit h, s, rdy;
    w0 = n_wr; r0 = n_rd;
    issue(1'b1, a, d, cyc, rd, h, s, rdy);
    chk(n_wr == w0 + 1 && last_wa == a && last_wd == d, {req, " write forwarded"},
        last_wd, d);
    chk(n_rd == r0, {req, " no line read on write"}, DW'(n_rd - r0), 0);
    chk(h == (kind != 0) && s == (kind == 2), {req, " write flags"},
        DW'({h, s}), DW'({kind != 0, kind == 2}));
    if (kind == 0) e_ms++;
    if (kind == 1) e_h1++;
    if (kind == 2) e_h2++;
  endtask

  localparam logic [AW-1:0] A = 16'h0010, B = 16'h0020, C = 16'h0034, D = 16'h0014,
                            E = 16'h0044, F = 16'h0077, G = 16'h0084, H = 16'h0101;

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req_valid, "R1 idle after reset",
        DW'({req_ready, resp_valid, mem_req_valid}), 32'h4);
    chk(cnt_hit1 == 0 && cnt_hit2 == 0 && cnt_miss == 0, "R1 counters zero",
        DW'(cnt_hit1 + cnt_hit2 + cnt_miss), 0);
  endtask

  task automatic t_primary_and_swap();
    rd_access(A, mval(A), 0, "R1 cold set skips probe");
    rd_access(A, mval(A), 1, "R2 primary hit");
    rd_access(B, mval(B), 0, "R5 double miss");
    rd_access(A, mval(A), 2, "R3 second-probe hit");
    rd_access(A, mval(A), 1, "R4 hit moved to primary");
    rd_access(B, mval(B), 2, "R5 displaced line on second probe");
  endtask

  task automatic t_skip_probe();
    rd_access(C, mval(C), 0, "R6 relocated set replaced");
    rd_access(B, mval(B), 1, "R6 alternate set untouched");
    rd_access(A, mval(A), 0, "R6 relocated line evicted");
  endtask

  task automatic t_alias();
    rd_access(E, mval(E), 0, "R6 fill on relocated set");
    rd_access(D, mval(D), 0, "R7 flipped alias not matched");
  endtask

  task automatic t_writes();
    wr_access(D, 32'hC0DE_0001, 1, "R8 write first-probe hit");
    rd_access(D, 32'hC0DE_0001, 1, "R8 updated word");
    wr_access(E, 32'hC0DE_0002, 2, "R8 write second-probe hit");
    rd_access(E, 32'hC0DE_0002, 1, "R8 updated and moved");
    wr_access(F, 32'hC0DE_0003, 0, "R9 write miss");
    rd_access(F, 32'hC0DE_0003, 0, "R9 no allocate");
    wr_access(G, 32'hC0DE_0004, 0, "R9 write miss on busy set");
    rd_access(E, 32'hC0DE_0002, 1, "R9 cache unchanged");
  endtask

  task automatic t_backpressure();
    mem_wait = 3;
    rd_access(H, mval(H), 0, "R11 fill under back-pressure");
    mem_wait = 0;
  endtask

  task automatic t_counters();
    @(negedge clk);
    chk(cnt_hit1 == CW'(e_h1), "R10 first-probe count", DW'(cnt_hit1), DW'(e_h1));
    chk(cnt_hit2 == CW'(e_h2), "R10 second-probe count", DW'(cnt_hit2), DW'(e_h2));
    chk(cnt_miss == CW'(e_ms), "R10 miss count", DW'(cnt_miss), DW'(e_ms));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_primary_and_swap();
    t_skip_probe();
    t_alias();
    t_writes();
    t_backpressure();
    t_counters();
    finish_run();
  end
endmodule